// File: doc/BRIEF.md
# Synchronous SRAM Byte-Write Front End

This block is a single-port synchronous static memory with a registered control front end and a flow-through read path. On every rising clock edge it registers the write data and the write controls. On an edge where the load-address input is high it also registers a new address and a new chip selection. From the write controls it decides whether the cycle writes every lane, writes only some byte lanes, or reads. It then applies that decision to an internal array.

The word is made of 2 or 4 lanes of 9 bits each. In lane i, bits 9i to 9i+7 are the data byte and bit 9i+8 is the parity bit. A captured write reaches the array on the following clock edge. A read comes combinationally from the array at the registered address, so it is valid in the cycle after the address is captured. An asynchronous output enable gates the data drivers. An asynchronous sleep input freezes all capture and keeps the stored contents.

Top module: `ssram_bw_top`

## Requirements
- R1: When `gw_n_i` is 0 at a capturing edge and the device is selected, every lane is written, parity bits included. `bwe_n_i` and `be_n_i` have no effect on that cycle.
- R2: When `gw_n_i` is 1, lane i is written only if `bwe_n_i` is 0 and `be_n_i[i]` is 0. Lane i covers `wdata_i[9i+8:9i]`, and bit 9i+8 is the parity bit. Lanes that do not qualify keep their previous contents.
- R3: When `gw_n_i` is 1 and no lane qualifies, the cycle is a read and the array is left unchanged.
- R4: The device is selected only when `cs1_n_i`=0, `cs2_n_i`=0 and `cs3_i`=1. An unselected cycle writes nothing and does not drive the output.
- R5: The address and the three chip enables are sampled only on edges where `ld_i`=1. When `ld_i`=0, the previous address and selection are kept, and any write goes to the held address.
- R6: While `sleep_i`=1, all other inputs are ignored, the array keeps its contents and the output is not driven.
- R7: `oe_n_i` acts combinationally. When `oe_n_i`=1, `dq_oe_o` is 0 and `dq_o` is high-impedance, with no clock edge needed.
- R8: Read data is flow-through. `dq_o` shows the array word at the registered address in the cycle after capture. It is driven (`dq_oe_o`=1) only if the device is selected, the cycle is a read, `oe_n_i`=0 and `sleep_i`=0.
- R9: A read of an address, captured on the edge right after a write to that address was captured, returns the newly written data.
- R10: After reset the device is unselected and `dq_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_i | input | 1 | Asynchronous sleep, active high |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| ld_i | input | 1 | Load a new address and chip selection |
| addr_i | input | AW | Word address |
| cs1_n_i | input | 1 | Chip enable, active low |
| cs2_n_i | input | 1 | Chip enable, active low |
| cs3_i | input | 1 | Chip enable, active high |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| be_n_i | input | LANES | Per-lane enables, active low |
| wdata_i | input | 9*LANES | Write data, lane i at bits 9i+8:9i |
| dq_o | output | 9*LANES | Read data, high-impedance when not driven |
| dq_oe_o | output | 1 | High while `dq_o` is driven |

## Verification
A write commits on the edge that follows its capture, and that same edge can capture a read of the same word. The bench provokes this by issuing a write followed at once by a read of its address, both as global writes and as partial byte writes. It judges the result by whether the flow-through output shows the merged word in the next low clock phase. The bench also holds `ld_i` low across write cycles while the address and chip enables change on the pins. It then judges, from later reads, that the writes landed on the held address under the held selection.

// File: rtl/ssram_bw_pkg.sv
// Package: shared lane geometry and the write decode used by the front end.
// Assumes each lane is 8 data bits plus 1 parity bit, with parity as the top bit.
package ssram_bw_pkg;
    localparam int LANE_BITS = 9;

    // Per-lane write mask: global write takes all lanes; otherwise lane i needs
    // both the byte-write enable and its own enable asserted (all active low).
    function automatic logic [3:0] lane_mask(input logic gw_n,
                                             input logic bwe_n,
                                             input logic [3:0] be_n,
                                             input int lanes);
        logic [3:0] m;
        for (int i = 0; i < 4; i++) begin
            if (i < lanes) m[i] = !gw_n || (!bwe_n && !be_n[i]);
            else           m[i] = 1'b0;
        end
        return m;
    endfunction
endpackage

// File: rtl/ssram_bw_wdec.sv
// Module: write decode. Combinationally turns the raw write strobes into a
// per-lane write mask. Assumes LANES is 2 or 4; unused inputs are ignored.
module ssram_bw_wdec
    import ssram_bw_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] be_n,
    output logic [LANES-1:0] lanes_wr
);
    logic [3:0] be_wide;
    logic [3:0] mask;

    // Widen the lane enables to the package's fixed four-lane form.
    always_comb begin
        be_wide = 4'hF;
        be_wide[LANES-1:0] = be_n;
    end

    // Apply the three-level decode.
    always_comb begin
        mask = lane_mask(gw_n, bwe_n, be_wide, LANES);
    end

    assign lanes_wr = mask[LANES-1:0];
endmodule

// File: rtl/ssram_bw_ctrl.sv
// Module: capture register. Registers data and write decode on every awake
// edge, and registers address and selection only when a load is requested.
// Assumes synchronous active-low reset; the sleep input freezes all capture.
module ssram_bw_ctrl #(
    parameter int LANES = 4,
    parameter int AW    = 8,
    localparam int DW   = 9 * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_i,
    input  logic             ld_i,
    input  logic [AW-1:0]    addr_i,
    input  logic             cs1_n_i,
    input  logic             cs2_n_i,
    input  logic             cs3_i,
    input  logic [LANES-1:0] lanes_wr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [AW-1:0]    addr_q,
    output logic             sel_q,
    output logic             rd_q,
    output logic [LANES-1:0] wr_lanes_q,
    output logic [DW-1:0]    wdata_q
);
    logic sel_next;

    // Selection for this edge: new chip enables on a load, else the held one.
    always_comb begin
        sel_next = ld_i ? (!cs1_n_i && !cs2_n_i && cs3_i) : sel_q;
    end

    // Address and selection register, updated only on awake load edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            sel_q  <= 1'b0;
        end else if (!sleep_i && ld_i) begin
            addr_q <= addr_i;
            sel_q  <= sel_next;
        end
    end

    // Cycle type register: write lanes or read, qualified by selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_lanes_q <= '0;
            rd_q       <= 1'b0;
        end else if (sleep_i) begin
            wr_lanes_q <= '0;
            rd_q       <= 1'b0;
        end else begin
            wr_lanes_q <= sel_next ? lanes_wr_i : '0;
            rd_q       <= sel_next && (lanes_wr_i == '0);
        end
    end

    // Write data register, held while asleep.
    always_ff @(posedge clk) begin
        if (!rst_n)        wdata_q <= '0;
        else if (!sleep_i) wdata_q <= wdata_i;
    end
endmodule

// File: rtl/ssram_bw_array.sv
// Module: storage array with per-lane write and a combinational read.
// Assumes one write port and one read port; contents are not reset.
module ssram_bw_array #(
    parameter int LANES = 4,
    parameter int AW    = 8,
    localparam int DW    = 9 * LANES,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic [LANES-1:0] we_lanes,
    input  logic [AW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] mem [DEPTH];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Commit one lane of the pending write.
        always_ff @(posedge clk) begin
            if (we_lanes[g]) mem[waddr][9*g +: 9] <= wdata[9*g +: 9];
        end
    end

    // Flow-through read at the registered address.
    assign rdata = mem[raddr];
endmodule

// File: rtl/ssram_bw_top.sv
// Module: top of the byte-write synchronous SRAM front end. It joins the decode,
// the capture register and the array, and gates the output drivers
// asynchronously. Assumes LANES is 2 or 4.
module ssram_bw_top #(
    parameter int LANES = 4,
    parameter int AW    = 8,
    localparam int DW   = 9 * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_i,
    input  logic             oe_n_i,
    input  logic             ld_i,
    input  logic [AW-1:0]    addr_i,
    input  logic             cs1_n_i,
    input  logic             cs2_n_i,
    input  logic             cs3_i,
    input  logic             gw_n_i,
    input  logic             bwe_n_i,
    input  logic [LANES-1:0] be_n_i,
    input  logic [DW-1:0]    wdata_i,
    output wire  [DW-1:0]    dq_o,
    output logic             dq_oe_o
);
    logic [LANES-1:0] lanes_wr;
    logic [AW-1:0]    addr_q;
    logic             sel_q;
    logic             rd_q;
    logic [LANES-1:0] wr_lanes_q;
    logic [DW-1:0]    wdata_q;
    logic [DW-1:0]    rd_data;

    ssram_bw_wdec #(.LANES(LANES)) u_wdec (
        .gw_n     (gw_n_i),
        .bwe_n    (bwe_n_i),
        .be_n     (be_n_i),
        .lanes_wr (lanes_wr)
    );

    ssram_bw_ctrl #(.LANES(LANES), .AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_i    (sleep_i),
        .ld_i       (ld_i),
        .addr_i     (addr_i),
        .cs1_n_i    (cs1_n_i),
        .cs2_n_i    (cs2_n_i),
        .cs3_i      (cs3_i),
        .lanes_wr_i (lanes_wr),
        .wdata_i    (wdata_i),
        .addr_q     (addr_q),
        .sel_q      (sel_q),
        .rd_q       (rd_q),
        .wr_lanes_q (wr_lanes_q),
        .wdata_q    (wdata_q)
    );

    ssram_bw_array #(.LANES(LANES), .AW(AW)) u_array (
        .clk      (clk),
        .we_lanes (wr_lanes_q),
        .waddr    (addr_q),
        .wdata    (wdata_q),
        .raddr    (addr_q),
        .rdata    (rd_data)
    );

    // Output drive qualification, asynchronous in output enable and sleep.
    always_comb begin
        dq_oe_o = sel_q && rd_q && !sleep_i && !oe_n_i;
    end

    assign dq_o = dq_oe_o ? rd_data : {DW{1'bz}};
endmodule

// File: rtl/ssram_bw_chk.sv
// Module: assertion checker for ssram_bw_top, attached by bind below.
// Assumes it observes the top's ports and its captured control state.
module ssram_bw_chk #(
    parameter int LANES = 4,
    parameter int AW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_i,
    input logic             oe_n_i,
    input logic             ld_i,
    input logic [AW-1:0]    addr_i,
    input logic             cs1_n_i,
    input logic             cs2_n_i,
    input logic             cs3_i,
    input logic             gw_n_i,
    input logic             bwe_n_i,
    input logic [LANES-1:0] be_n_i,
    input logic             dq_oe_o,
    input logic [AW-1:0]    addr_q,
    input logic             sel_q,
    input logic             rd_q,
    input logic [LANES-1:0] wr_lanes_q
);
    // R1: a selected global write enables every lane
    a_r1_global_all: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && ld_i && !cs1_n_i && !cs2_n_i && cs3_i && !gw_n_i)
        |=> (wr_lanes_q == {LANES{1'b1}}));

    // R3: no qualifying lane means no write
    a_r3_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_n_i && bwe_n_i) |=> (wr_lanes_q == '0));

    // R4: nothing is written or driven while unselected
    a_r4_unsel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q |-> (wr_lanes_q == '0 && !dq_oe_o));

    // R5: address and selection hold without a load
    a_r5_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> ($stable(addr_q) && $stable(sel_q)));

    // R6: sleep suppresses drive and new writes
    a_r6_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (wr_lanes_q == '0));

    // R7: output enable high blocks drive
    a_r7_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n_i || sleep_i) |-> !dq_oe_o);

    // R8: drive only in a selected read cycle
    a_r8_drive_read: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_o |-> (sel_q && wr_lanes_q == '0));
endmodule

bind ssram_bw_top ssram_bw_chk #(.LANES(LANES), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_i    (sleep_i),
    .oe_n_i     (oe_n_i),
    .ld_i       (ld_i),
    .addr_i     (addr_i),
    .cs1_n_i    (cs1_n_i),
    .cs2_n_i    (cs2_n_i),
    .cs3_i      (cs3_i),
    .gw_n_i     (gw_n_i),
    .bwe_n_i    (bwe_n_i),
    .be_n_i     (be_n_i),
    .dq_oe_o    (dq_oe_o),
    .addr_q     (addr_q),
    .sel_q      (sel_q),
    .rd_q       (rd_q),
    .wr_lanes_q (wr_lanes_q)
);

// File: tb/ssram_bw_top_tb.sv
// Bench: directed scenarios for ssram_bw_top, one task each. Inputs change on
// the falling edge; outputs are sampled on the falling edge after a capture.
module ssram_bw_top_tb;
    localparam int LANES = 4;
    localparam int AW    = 6;
    localparam int DW    = 9 * LANES;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sleep_i = 1'b0;
    logic             oe_n_i = 1'b0;
    logic             ld_i = 1'b0;
    logic [AW-1:0]    addr_i = '0;
    logic             cs1_n_i = 1'b1;
    logic             cs2_n_i = 1'b1;
    logic             cs3_i = 1'b0;
    logic             gw_n_i = 1'b1;
    logic             bwe_n_i = 1'b1;
    logic [LANES-1:0] be_n_i = '1;
    logic [DW-1:0]    wdata_i = '0;
    wire  [DW-1:0]    dq_o;
    logic             dq_oe_o;

    int n_run  = 0;
    int n_fail = 0;

    localparam logic [DW-1:0] VAL_A = {9'h1AA, 9'h0BB, 9'h1CC, 9'h0DD};
    localparam logic [DW-1:0] VAL_B = {9'h111, 9'h122, 9'h133, 9'h144};
    localparam logic [DW-1:0] VAL_M = {9'h1AA, 9'h122, 9'h1CC, 9'h144};
    localparam logic [DW-1:0] VAL_D = {9'h0F0, 9'h10F, 9'h055, 9'h1A5};
    localparam logic [DW-1:0] VAL_E = {9'h001, 9'h002, 9'h003, 9'h004};

    always #10 clk = ~clk;

    ssram_bw_top #(.LANES(LANES), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .oe_n_i(oe_n_i),
        .ld_i(ld_i), .addr_i(addr_i), .cs1_n_i(cs1_n_i), .cs2_n_i(cs2_n_i),
        .cs3_i(cs3_i), .gw_n_i(gw_n_i), .bwe_n_i(bwe_n_i), .be_n_i(be_n_i),
        .wdata_i(wdata_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
    );

    // Compare the output against an expected drive state and, if driven, data.
    task automatic check(input string req, input logic exp_oe, input logic [DW-1:0] exp_d);
        n_run++;
        if (dq_oe_o !== exp_oe || (exp_oe && dq_o !== exp_d)) begin
            n_fail++;
            $display("FAIL %s: oe=%0b dq=%h expected oe=%0b dq=%h", req, dq_oe_o, dq_o, exp_oe, exp_d);
        end
    endtask

    // Apply one clock cycle of inputs; return at the following falling edge.
    task automatic cyc(input logic ld, input logic [AW-1:0] a, input logic c1n,
                       input logic c2n, input logic c3, input logic gwn,
                       input logic bwen, input logic [LANES-1:0] ben,
                       input logic [DW-1:0] d);
        ld_i = ld; addr_i = a; cs1_n_i = c1n; cs2_n_i = c2n; cs3_i = c3;
        gw_n_i = gwn; bwe_n_i = bwen; be_n_i = ben; wdata_i = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_all(input logic [AW-1:0] a, input logic [DW-1:0] d);
        cyc(1'b1, a, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, '1, d);
    endtask

    task automatic rd(input logic [AW-1:0] a);
        cyc(1'b1, a, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, '1, '0);
    endtask

    task automatic t_reset;
        check("R10 reset unselected", 1'b0, '0);
    endtask

    task automatic t_global;
        wr_all(6'd3, VAL_A);
        check("R8 no drive in write cycle", 1'b0, '0);
        rd(6'd3);
        check("R1 R9 global write then read", 1'b1, VAL_A);
    endtask

    task automatic t_bytes;
        cyc(1'b1, 6'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b1010, VAL_B);
        rd(6'd3);
        check("R2 R9 lanes 0,2 merged", 1'b1, VAL_M);
    endtask

    task automatic t_no_bwe;
        cyc(1'b1, 6'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0000, VAL_E);
        check("R3 read cycle drives old data", 1'b1, VAL_M);
        rd(6'd3);
        check("R3 array unchanged", 1'b1, VAL_M);
    endtask

    task automatic t_select;
        wr_all(6'd5, VAL_D);
        cyc(1'b1, 6'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '1, VAL_E);
        check("R4 cs3 low not driven", 1'b0, '0);
        cyc(1'b1, 6'd5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '1, '0);
        check("R4 cs1 high not driven", 1'b0, '0);
        cyc(1'b1, 6'd5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '1, '0);
        check("R4 cs2 high not driven", 1'b0, '0);
        rd(6'd5);
        check("R4 unselected write ignored", 1'b1, VAL_D);
    endtask

    task automatic t_hold;
        rd(6'd5);
        cyc(1'b0, 6'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '1, '0);
        check("R5 held address and selection", 1'b1, VAL_D);
        cyc(1'b0, 6'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1110, VAL_E);
        rd(6'd5);
        check("R5 write to held address", 1'b1, {VAL_D[35:9], VAL_E[8:0]});
        rd(6'd3);
        check("R5 other address untouched", 1'b1, VAL_M);
    endtask

    task automatic t_sleep;
        rd(6'd5);
        sleep_i = 1'b1;
        #1;
        check("R6 sleep stops drive", 1'b0, '0);
        wr_all(6'd5, VAL_B);
        cyc(1'b1, 6'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, '1, VAL_B);
        check("R6 asleep not driven", 1'b0, '0);
        sleep_i = 1'b0;
        rd(6'd5);
        check("R6 contents kept addr 5", 1'b1, {VAL_D[35:9], VAL_E[8:0]});
        rd(6'd3);
        check("R6 contents kept addr 3", 1'b1, VAL_M);
    endtask

    task automatic t_oe;
        rd(6'd3);
        oe_n_i = 1'b1;
        #2;
        check("R7 oe high blocks drive", 1'b0, '0);
        oe_n_i = 1'b0;
        #2;
        check("R7 oe low restores drive", 1'b1, VAL_M);
    endtask

    task automatic t_flow;
        wr_all(6'd7, VAL_E);
        rd(6'd7);
        check("R8 R9 flow-through new word", 1'b1, VAL_E);
        rd(6'd5);
        check("R8 next address next cycle", 1'b1, {VAL_D[35:9], VAL_E[8:0]});
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_global();
                t_bytes();
                t_no_bwe();
                t_select();
                t_hold();
                t_sleep();
                t_oe();
                t_flow();
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule